// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block carries out a single branch step of a one-wire ROM search as one hardware operation. The controller starts it with a preferred direction. The sequencer asks a slot generator for a read slot that returns the ID bit, and then for a second read slot that returns the complement bit. It then decides which branch to follow. If at least one device answered, it requests a write slot that drives the chosen direction onto the bus.

The outcome is packed into a 3-bit code, presented together with a one-cycle done pulse. Bit 0 is the ID bit, bit 1 is the complement bit and bit 2 is the direction taken. Every slot has to complete within a programmable number of cycles. If one does not, the step stops early, returns the no-response code and raises a timeout flag. The slot generator and the outer 64-bit search loop, with its discrepancy bookkeeping, live outside this block.

Top module: `onewire_triplet_seq`

## Requirements
- R1: An accepted start issues slot requests in this order: a read slot (`slot_write_o`=0) for the ID bit, a read slot for the complement bit, then at most one write slot (`slot_write_o`=1).
- R2: When both read bits are 1, `result_o` is 3, no write slot is requested and `timeout_o` stays 0.
- R3: When both read bits are 0, the direction `dir_i` captured at start is written; `result_o` is 4 for direction 1 and 0 for direction 0.
- R4: When exactly one read bit is 1, the direction written equals the ID bit; `result_o` is 5 when the ID bit is 1 and 2 when it is 0.
- R5: A new slot request is issued only after the current slot's completion; each request is a single-cycle pulse.
- R6: `result_o` encodes bit 0 = ID bit, bit 1 = complement bit, bit 2 = direction taken.
- R7: If a slot's completion has not arrived within `limit_i` cycles, the step ends with `result_o` = 3, `timeout_o` = 1, and no further slot is requested.
- R8: `done_o` is high for exactly one cycle per accepted start, with `result_o` valid in that cycle; `timeout_o` rises only together with `done_o` and holds until the next accepted start.
- R9: A start pulse while `busy_o` is high is ignored: no extra slots and no extra done.
- R10: After reset the block is idle: `busy_o`, `done_o`, `slot_req_o` and `timeout_o` are all 0.
- R11: A read slot advances only on `slot_rx_done_i`, and a write slot only on `slot_tx_done_i`. A completion of the other kind is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one search step (honoured only when idle) |
| dir_i | input | 1 | Preferred direction, used when both read bits are 0 |
| limit_i | input | LIMIT_W | Cycle limit for each slot completion |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle pulse: result is valid |
| result_o | output | 3 | {direction taken, complement bit, ID bit} |
| timeout_o | output | 1 | The last step aborted on a slot timeout |
| slot_req_o | output | 1 | One-cycle request for a bit slot |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_bit_o | output | 1 | Value to drive in a write slot |
| slot_rx_done_i | input | 1 | Read slot completed |
| slot_rx_bit_i | input | 1 | Bit sampled in the read slot, valid with slot_rx_done_i |
| slot_tx_done_i | input | 1 | Write slot completed |

## Verification
The hardest cases to reach are an abort in one chosen slot, in particular in the final write slot after both reads have succeeded, and a completion of the wrong kind arriving while a slot is pending. The bench uses a responder model of the slot generator that can be told, for each step, to withhold the answer to one specific slot. It can also send a mismatched completion pulse before the real one, which makes both situations reachable from the ports. A start pulse injected in the middle of a step checks that such a request is discarded.

// File: rtl/tri_seq_pkg.sv
package tri_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ID_REQ  = 3'd1,
        ST_ID_WAIT = 3'd2,
        ST_CP_REQ  = 3'd3,
        ST_CP_WAIT = 3'd4,
        ST_WR_REQ  = 3'd5,
        ST_WR_WAIT = 3'd6,
        ST_FINISH  = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       id_bit;
        logic       cp_bit;
        logic       pref;
        logic       take;
        logic       tmo;
    } seq_regs_t;

    localparam int RESULT_W = 3;

endpackage

// File: rtl/tri_decide.sv
// Branch decision for one search step.
module tri_decide (
    input  logic id_bit_i,
    input  logic cp_bit_i,
    input  logic pref_i,
    output logic take_o,
    output logic skip_write_o
);
    always_comb begin
        skip_write_o = id_bit_i & cp_bit_i;
        if (skip_write_o) begin
            take_o = 1'b0;
        end else if (!id_bit_i && !cp_bit_i) begin
            take_o = pref_i;      // both branches populated: follow request
        end else begin
            take_o = id_bit_i;    // single branch: forced
        end
    end
endmodule

// File: rtl/slot_watch.sv
// Counts waiting cycles of a pending slot and flags when the limit is reached.
module slot_watch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/onewire_triplet_seq.sv
module onewire_triplet_seq
    import tri_seq_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                dir_i,
    input  logic [LIMIT_W-1:0]  limit_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [RESULT_W-1:0] result_o,
    output logic                timeout_o,
    output logic                slot_req_o,
    output logic                slot_write_o,
    output logic                slot_bit_o,
    input  logic                slot_rx_done_i,
    input  logic                slot_rx_bit_i,
    input  logic                slot_tx_done_i
);
    seq_regs_t r_d, r_q;

    logic in_req, in_wait, expired;
    logic dec_take, dec_skip;

    assign in_req  = (r_q.st == ST_ID_REQ) || (r_q.st == ST_CP_REQ) ||
                     (r_q.st == ST_WR_REQ);
    assign in_wait = (r_q.st == ST_ID_WAIT) || (r_q.st == ST_CP_WAIT) ||
                     (r_q.st == ST_WR_WAIT);

    slot_watch #(.CNT_W(LIMIT_W)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (in_req),
        .run_i     (in_wait),
        .limit_i   (limit_i),
        .expired_o (expired)
    );

    // Decision uses the live complement bit so no extra cycle is spent.
    tri_decide u_decide (
        .id_bit_i     (r_q.id_bit),
        .cp_bit_i     (slot_rx_bit_i),
        .pref_i       (r_q.pref),
        .take_o       (dec_take),
        .skip_write_o (dec_skip)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_ID_REQ;
                    r_d.pref   = dir_i;
                    r_d.id_bit = 1'b0;
                    r_d.cp_bit = 1'b0;
                    r_d.take   = 1'b0;
                    r_d.tmo    = 1'b0;
                end
            end
            ST_ID_REQ: r_d.st = ST_ID_WAIT;
            ST_ID_WAIT: begin
                if (slot_rx_done_i) begin
                    r_d.id_bit = slot_rx_bit_i;
                    r_d.st     = ST_CP_REQ;
                end else if (expired) begin
                    r_d.st     = ST_FINISH;
                    r_d.id_bit = 1'b1;
                    r_d.cp_bit = 1'b1;
                    r_d.take   = 1'b0;
                    r_d.tmo    = 1'b1;
                end
            end
            ST_CP_REQ: r_d.st = ST_CP_WAIT;
            ST_CP_WAIT: begin
                if (slot_rx_done_i) begin
                    r_d.cp_bit = slot_rx_bit_i;
                    r_d.take   = dec_take;
                    r_d.st     = dec_skip ? ST_FINISH : ST_WR_REQ;
                end else if (expired) begin
                    r_d.st     = ST_FINISH;
                    r_d.id_bit = 1'b1;
                    r_d.cp_bit = 1'b1;
                    r_d.take   = 1'b0;
                    r_d.tmo    = 1'b1;
                end
            end
            ST_WR_REQ: r_d.st = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (slot_tx_done_i) begin
                    r_d.st = ST_FINISH;
                end else if (expired) begin
                    r_d.st     = ST_FINISH;
                    r_d.id_bit = 1'b1;
                    r_d.cp_bit = 1'b1;
                    r_d.take   = 1'b0;
                    r_d.tmo    = 1'b1;
                end
            end
            ST_FINISH: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, id_bit: 1'b0, cp_bit: 1'b0,
                     pref: 1'b0, take: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = (r_q.st == ST_FINISH);
    assign result_o     = {r_q.take, r_q.cp_bit, r_q.id_bit};
    assign timeout_o    = r_q.tmo;
    assign slot_req_o   = in_req;
    assign slot_write_o = (r_q.st == ST_WR_REQ);
    assign slot_bit_o   = r_q.take;
endmodule

// File: rtl/tri_seq_checker.sv
module tri_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] result_o,
    input logic       timeout_o,
    input logic       slot_req_o,
    input logic       slot_write_o
);
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            wrote_q <= 1'b0;
        end else if (slot_req_o && slot_write_o) begin
            wrote_q <= 1'b1;
        end
    end

    // R8
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    a_r8_tmo_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o);
    // R7
    a_r7_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> (result_o == 3'd3));
    // R2
    a_r2_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !timeout_o && result_o == 3'd3) |-> !wrote_q);
    // R5
    a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o |=> !slot_req_o);
    // R9
    a_r9_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o |-> busy_o);
    // R4 R6
    a_r4_forced_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (result_o[0] ^ result_o[1])) |-> (result_o[2] == result_o[0]));
endmodule

bind onewire_triplet_seq tri_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .timeout_o    (timeout_o),
    .slot_req_o   (slot_req_o),
    .slot_write_o (slot_write_o)
);

// File: tb/sim_onewire_triplet_seq.sv
`timescale 1ns/1ps
module sim_onewire_triplet_seq;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic dir_i = 1'b0;
    logic [LW-1:0] limit_i = 16'd10;
    logic busy_o, done_o, timeout_o, slot_req_o, slot_write_o, slot_bit_o;
    logic [2:0] result_o;
    logic slot_rx_done_i = 1'b0;
    logic slot_rx_bit_i = 1'b0;
    logic slot_tx_done_i = 1'b0;

    always #10 clk = ~clk;

    onewire_triplet_seq #(.LIMIT_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .limit_i(limit_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .timeout_o(timeout_o),
        .slot_req_o(slot_req_o), .slot_write_o(slot_write_o),
        .slot_bit_o(slot_bit_o), .slot_rx_done_i(slot_rx_done_i),
        .slot_rx_bit_i(slot_rx_bit_i), .slot_tx_done_i(slot_tx_done_i)
    );

    typedef struct packed {
        logic [2:0] res;
        logic       tmo;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;

    // responder configuration and log
    logic cfg_id, cfg_cp;
    int   cfg_delay = 1;
    int   cfg_drop = 9;
    bit   cfg_wrong = 0;
    int   nslots = 0;
    logic kind_log [0:3];
    logic wbit_log = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // responder: model of the slot generator
    initial begin
        @(negedge clk);
        forever begin
            if (rst_n && slot_req_o) begin
                int idx;
                logic is_wr;
                idx = nslots;
                is_wr = slot_write_o;
                if (idx < 4) kind_log[idx] = is_wr;
                if (is_wr) wbit_log = slot_bit_o;
                nslots++;
                if (idx == cfg_drop) begin
                    @(negedge clk);
                end else begin
                    if (cfg_wrong) begin
                        @(negedge clk);
                        if (is_wr) begin
                            slot_rx_done_i = 1'b1;
                            slot_rx_bit_i  = 1'b1;
                        end else begin
                            slot_tx_done_i = 1'b1;
                        end
                        @(negedge clk);
                        chk(!slot_req_o, "R11", "request after wrong-kind completion", 1, 0);
                        slot_rx_done_i = 1'b0;
                        slot_tx_done_i = 1'b0;
                    end
                    for (int k = 0; k < cfg_delay; k++) begin
                        @(negedge clk);
                        chk(!slot_req_o, "R5", "request while slot pending", 1, 0);
                    end
                    if (is_wr) begin
                        slot_tx_done_i = 1'b1;
                    end else begin
                        slot_rx_done_i = 1'b1;
                        slot_rx_bit_i  = (idx == 0) ? cfg_id : cfg_cp;
                    end
                    @(negedge clk);
                    slot_rx_done_i = 1'b0;
                    slot_tx_done_i = 1'b0;
                end
            end else begin
                @(negedge clk);
            end
        end
    end

    // monitor: pops expected results as done pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "done with no step pending", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result_o == e.res, "R6", "result code", result_o, e.res);
                    chk(timeout_o == e.tmo, "R7", "timeout flag at done", timeout_o, e.tmo);
                end
            end
        end
    end

    task automatic run_op(input logic dir, input logic id, input logic cp,
                          input int delay, input int drop, input bit wrong,
                          input bit extra, input string req);
        exp_t e;
        int exp_n;
        logic exp_w;
        int cyc;
        cfg_id = id; cfg_cp = cp; cfg_delay = delay; cfg_drop = drop;
        cfg_wrong = wrong; nslots = 0;
        kind_log[0] = 1'bx; kind_log[1] = 1'bx; kind_log[2] = 1'bx; kind_log[3] = 1'bx;
        exp_w = (id ^ cp) ? id : dir;
        if (drop < 3 && !(drop == 2 && id && cp)) begin
            e.res = 3'd3; e.tmo = 1'b1; exp_n = drop + 1;
        end else if (id && cp) begin
            e.res = 3'd3; e.tmo = 1'b0; exp_n = 2;
        end else begin
            e.res = {exp_w, cp, id}; e.tmo = 1'b0; exp_n = 3;
        end
        exp_q.push_back(e);
        start_i = 1'b1; dir_i = dir;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (extra && cyc == 3) begin
                start_i = 1'b1; dir_i = ~dir;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk(cyc < 400, req, "step completion", cyc, 0);
        repeat (6) @(negedge clk);
        chk(nslots == exp_n, req, "slot count", nslots, exp_n);
        chk(kind_log[0] === 1'b0, "R1", "first slot is read", int'(kind_log[0]), 0);
        if (exp_n >= 2) chk(kind_log[1] === 1'b0, "R1", "second slot is read", int'(kind_log[1]), 0);
        if (exp_n == 3) begin
            chk(kind_log[2] === 1'b1, "R1", "third slot is write", int'(kind_log[2]), 1);
            chk(wbit_log == exp_w, req, "written direction", wbit_log, exp_w);
        end
        chk(!busy_o, req, "idle after step", busy_o, 0);
        chk(timeout_o == e.tmo, "R8", "timeout flag held", timeout_o, e.tmo);
        chk(exp_q.size() == 0, req, "done pulses outstanding", exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R10", "busy after reset", busy_o, 0);
        chk(!done_o, "R10", "done after reset", done_o, 0);
        chk(!slot_req_o, "R10", "slot request after reset", slot_req_o, 0);
        chk(!timeout_o, "R10", "timeout after reset", timeout_o, 0);

        // no device answered
        run_op(1'b0, 1'b1, 1'b1, 1, 9, 0, 0, "R2");
        run_op(1'b1, 1'b1, 1'b1, 3, 9, 0, 0, "R2");
        // conflict: requested direction
        run_op(1'b1, 1'b0, 1'b0, 1, 9, 0, 0, "R3");
        run_op(1'b0, 1'b0, 1'b0, 2, 9, 0, 0, "R3");
        // single branch: forced direction
        run_op(1'b0, 1'b1, 1'b0, 1, 9, 0, 0, "R4");
        run_op(1'b1, 1'b0, 1'b1, 4, 9, 0, 0, "R4");
        run_op(1'b1, 1'b1, 1'b0, 2, 9, 0, 0, "R4");
        // wrong-kind completions first
        run_op(1'b1, 1'b0, 1'b0, 2, 9, 1, 0, "R11");
        run_op(1'b0, 1'b0, 1'b1, 1, 9, 1, 0, "R11");
        // start while busy
        run_op(1'b0, 1'b0, 1'b0, 3, 9, 0, 1, "R9");
        run_op(1'b1, 1'b1, 1'b1, 3, 9, 0, 1, "R9");
        // timeouts in each slot
        run_op(1'b1, 1'b0, 1'b0, 1, 0, 0, 0, "R7");
        run_op(1'b0, 1'b1, 1'b0, 1, 1, 0, 0, "R7");
        run_op(1'b1, 1'b0, 1'b0, 1, 2, 0, 0, "R7");
        // next good step clears the flag
        run_op(1'b1, 1'b1, 1'b0, 1, 9, 0, 0, "R8");
        // tighter limit, reply still in time
        limit_i = 16'd3;
        run_op(1'b0, 1'b0, 1'b1, 2, 9, 0, 0, "R7");
        run_op(1'b1, 1'b0, 1'b0, 1, 2, 0, 0, "R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule